// File: doc/BRIEF.md
# Privilege-Split Address Translation Cache

This block caches logical-to-physical page mappings for a processor core. It holds two direct-mapped banks of entries, one used by user-mode accesses and one by supervisor-mode accesses. A lookup presents a logical address, a privilege bit, a data/instruction bit and a write bit. On a hit the block returns the physical address (cached page frame joined to the untranslated page offset) with the protection flags, or a fault indication when the access is not allowed.

On a miss, and on a write that hits an entry whose modified flag is clear, the block raises a fill request to an external translator. That translator performs the table walk and the transparent-region matching. The block stores the returned descriptor and then answers the lookup from it. With translation switched off, a miss is served internally by an identity mapping.

Entries are invalidated by address or all at once. Either kind of flush can spare entries marked global. In 8K-page mode an address flush also covers the paired index. A write to the translation-control register clears everything, global entries included.

Top module: `xlate_cache`

## Requirements
- R1: After reset every entry of both banks is empty, `lk_ready` is 1, and `res_valid` and `fill_req` are 0; the first lookup of any address misses.
- R2: A lookup accepted while `lk_ready` is 1 that hits an entry raises `res_valid` for one cycle on the next clock. `res_phys` is the entry's page frame above bit 12 joined to `lk_addr[11:0]`. `res_global`, `res_tt` and `res_wp` reflect the entry's flags. No fill request is made.
- R3: A miss with `xlat_en`=1 raises `fill_req` on the next clock, carrying the lookup's address, privilege, kind and write bits, and holds it until `fill_ack`. The response (frame, global, transparent, modified, write-protect, data-valid, instruction-valid) is stored, and the result appears on the clock after the acknowledge.
- R4: The bank is chosen by `lk_super`; a mapping stored for one privilege does not hit for the other.
- R5: A write lookup that hits an entry whose modified flag is 0 is handled as a miss and refilled; after a refill with modified set, further writes hit.
- R6: `res_fault` is 1 when the entry's valid flag for the access kind is 0 (data-valid for `lk_data`=1, instruction-valid for `lk_data`=0), or when a write hits an entry whose write-protect flag is 1.
- R7: With `xlat_en`=0 a miss makes no fill request. It stores an identity mapping that is valid for both kinds, global, modified and not write-protected, and the result appears on the next clock.
- R8: A flush by address (`fl_valid`=1, `fl_all`=0) empties index `fl_addr[15:12]` in the bank selected by `fl_super` only. An entry whose global flag is set is kept unless `fl_global` is 1.
- R9: With `page8k`=1 a flush by address also empties the index with bit 0 inverted, under the same global rule; with `page8k`=0 that neighbour is untouched.
- R10: A flush-all (`fl_all`=1) clears one index of both banks per clock under the global rule of `fl_global`. `lk_ready` stays 0 for exactly 16 cycles, and no lookup is accepted meanwhile.
- R11: A pulse on `tc_write` runs a flush-all that also clears global entries.
- R12: The index is `lk_addr[15:12]` and the tag is `lk_addr[31:16]`; an access with another tag at the same index replaces the entry. Command priority when accepted together: `tc_write`, then `fl_valid`, then `lk_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, empties all entries |
| xlat_en | input | 1 | Translation enabled; 0 selects identity fills |
| page8k | input | 1 | 8K-page mode for address flushes |
| tc_write | input | 1 | Translation-control write, global flush-all |
| fl_valid | input | 1 | Flush command strobe |
| fl_all | input | 1 | Flush command covers all entries |
| fl_global | input | 1 | Flush also clears global entries |
| fl_super | input | 1 | Bank of an address flush |
| fl_addr | input | 32 | Address of an address flush |
| lk_valid | input | 1 | Lookup strobe |
| lk_ready | output | 1 | Block idle, commands accepted |
| lk_addr | input | 32 | Logical address of lookup |
| lk_super | input | 1 | Lookup in supervisor mode |
| lk_data | input | 1 | 1 data access, 0 instruction fetch |
| lk_write | input | 1 | Lookup is a write |
| res_valid | output | 1 | Result strobe |
| res_phys | output | 32 | Translated physical address |
| res_fault | output | 1 | Access not permitted |
| res_global | output | 1 | Entry is global |
| res_tt | output | 1 | Entry came from a transparent region |
| res_wp | output | 1 | Entry is write-protected |
| fill_req | output | 1 | Fill request to translator |
| fill_addr | output | 32 | Address to translate |
| fill_super | output | 1 | Privilege of fill |
| fill_data | output | 1 | Kind of fill |
| fill_write | output | 1 | Fill caused by a write |
| fill_ack | input | 1 | Translator response strobe |
| fill_ppn | input | 20 | Physical page frame |
| fill_global | input | 1 | Response global flag |
| fill_tt | input | 1 | Response transparent flag |
| fill_mod | input | 1 | Response modified flag |
| fill_wp | input | 1 | Response write-protect flag |
| fill_vd | input | 1 | Response valid for data |
| fill_vi | input | 1 | Response valid for instruction |

## Verification
The lookup path is driven by a sequence that mixes cold misses, hits at several page offsets, the same address under the other privilege, and instruction fetches against a data-only page. It adds writes to protected, unmodified and modified pages, and a second tag at an occupied index. Together these separate a hit from a refill, one bank from the other, the two valid flags, and a protection fault from an eviction. Flushes are tried against global and non-global entries, with 8K pairing on and off. The busy window of both flush-all forms is measured, so a partial or overlong sweep, a wrong bank or a lost global entry each show up as a wrong hit or miss afterwards.

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int AW = 32,
  parameter int PS = 12,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xlat_en,
  input  logic          page8k,
  input  logic          tc_write,
  input  logic          fl_valid,
  input  logic          fl_all,
  input  logic          fl_global,
  input  logic          fl_super,
  input  logic [AW-1:0] fl_addr,
  input  logic          lk_valid,
  output logic          lk_ready,
  input  logic [AW-1:0] lk_addr,
  input  logic          lk_super,
  input  logic          lk_data,
  input  logic          lk_write,
  output logic          res_valid,
  output logic [AW-1:0] res_phys,
  output logic          res_fault,
  output logic          res_global,
  output logic          res_tt,
  output logic          res_wp,
  output logic          fill_req,
  output logic [AW-1:0] fill_addr,
  output logic          fill_super,
  output logic          fill_data,
  output logic          fill_write,
  input  logic          fill_ack,
  input  logic [AW-PS-1:0] fill_ppn,
  input  logic          fill_global,
  input  logic          fill_tt,
  input  logic          fill_mod,
  input  logic          fill_wp,
  input  logic          fill_vd,
  input  logic          fill_vi
);
  localparam int N  = 1 << IW;
  localparam int TW = AW - PS - IW + 1;
  localparam int PW = AW - PS;
  localparam logic [TW-1:0] EMPTY = {1'b1, {(TW-1){1'b0}}};
  localparam int F_G = 5, F_T = 4, F_M = 3, F_W = 2, F_D = 1, F_I = 0;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_FLUSH} st_t;

  st_t           state;
  logic [IW-1:0] cnt;
  logic          fa_glob;
  logic [TW-1:0] tag_q [2][N];
  logic [PW-1:0] ppn_q [2][N];
  logic [5:0]    flg_q [2][N];
  logic [AW-1:0] q_addr;
  logic          q_super, q_data, q_write;
  logic [PW-1:0] r_ppn;
  logic [PS-1:0] r_off;

  wire [IW-1:0] lk_idx   = lk_addr[PS+IW-1:PS];
  wire [TW-1:0] lk_tag   = {1'b0, lk_addr[AW-1:PS+IW]};
  wire [5:0]    lk_f     = flg_q[lk_super][lk_idx];
  wire          lk_hit   = (tag_q[lk_super][lk_idx] == lk_tag) && !(lk_write && !lk_f[F_M]);
  wire          lk_go    = (state == S_IDLE) && lk_valid && !tc_write && !fl_valid;
  wire          fl_go    = (state == S_IDLE) && fl_valid && !tc_write && !fl_all;
  wire [IW-1:0] fl_idx   = fl_addr[PS+IW-1:PS];
  wire          in_wait  = (state == S_WAIT);

  wire          wr_en    = (lk_go && !lk_hit && !xlat_en) || (in_wait && fill_ack);
  wire          wr_bank  = in_wait ? q_super : lk_super;
  wire [AW-1:0] wr_addr  = in_wait ? q_addr : lk_addr;
  wire [PW-1:0] wr_ppn   = in_wait ? fill_ppn : lk_addr[AW-1:PS];
  wire [5:0]    wr_flg   = in_wait ? {fill_global, fill_tt, fill_mod, fill_wp, fill_vd, fill_vi}
                                   : 6'b101011;
  wire          use_hit  = lk_go && lk_hit;
  wire [5:0]    o_flg    = use_hit ? lk_f : wr_flg;
  wire          o_data   = in_wait ? q_data : lk_data;
  wire          o_write  = in_wait ? q_write : lk_write;
  wire          o_fault  = !(o_data ? o_flg[F_D] : o_flg[F_I]) || (o_write && o_flg[F_W]);

  assign lk_ready   = (state == S_IDLE);
  assign res_phys   = {r_ppn, r_off};
  assign fill_addr  = q_addr;
  assign fill_super = q_super;
  assign fill_data  = q_data;
  assign fill_write = q_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt <= '0;
      fa_glob <= 1'b0;
      fill_req <= 1'b0;
      res_valid <= 1'b0;
      res_fault <= 1'b0;
      res_global <= 1'b0;
      res_tt <= 1'b0;
      res_wp <= 1'b0;
      r_ppn <= '0;
      r_off <= '0;
      q_addr <= '0;
      q_super <= 1'b0;
      q_data <= 1'b0;
      q_write <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < N; i++) begin
          tag_q[b][i] <= EMPTY;
          ppn_q[b][i] <= '0;
          flg_q[b][i] <= '0;
        end
    end else begin
      res_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (tc_write) begin
            state <= S_FLUSH; cnt <= '0; fa_glob <= 1'b1;
          end else if (fl_valid && fl_all) begin
            state <= S_FLUSH; cnt <= '0; fa_glob <= fl_global;
          end else if (lk_go) begin
            q_addr <= lk_addr; q_super <= lk_super;
            q_data <= lk_data; q_write <= lk_write;
            if (!lk_hit && xlat_en) begin
              fill_req <= 1'b1;
              state <= S_WAIT;
            end
          end
        end
        S_WAIT: if (fill_ack) begin
          fill_req <= 1'b0;
          state <= S_IDLE;
        end
        S_FLUSH: begin
          for (int b = 0; b < 2; b++)
            if (fa_glob || !flg_q[b][cnt][F_G]) tag_q[b][cnt] <= EMPTY;
          cnt <= cnt + 1'b1;
          if (cnt == IW'(N-1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase

      if (fl_go) begin
        if (fl_global || !flg_q[fl_super][fl_idx][F_G]) tag_q[fl_super][fl_idx] <= EMPTY;
        if (page8k && (fl_global || !flg_q[fl_super][fl_idx ^ 1'b1][F_G]))
          tag_q[fl_super][fl_idx ^ 1'b1] <= EMPTY;
      end

      if (wr_en) begin
        tag_q[wr_bank][wr_addr[PS+IW-1:PS]] <= {1'b0, wr_addr[AW-1:PS+IW]};
        ppn_q[wr_bank][wr_addr[PS+IW-1:PS]] <= wr_ppn;
        flg_q[wr_bank][wr_addr[PS+IW-1:PS]] <= wr_flg;
      end

      if (wr_en || use_hit) begin
        res_valid  <= 1'b1;
        r_ppn      <= use_hit ? ppn_q[lk_super][lk_idx] : wr_ppn;
        r_off      <= wr_addr[PS-1:0];
        res_fault  <= o_fault;
        res_global <= o_flg[F_G];
        res_tt     <= o_flg[F_T];
        res_wp     <= o_flg[F_W];
      end
    end
  end

  p_fill_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_ack |=> fill_req && $stable(fill_addr));
  p_ack_only_on_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ack |-> fill_req);
  p_wp_write_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && q_write && !res_fault |-> !res_wp);
  p_no_fill_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_req) |-> $past(xlat_en));
  p_quiet_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_ready && !fill_req |-> !res_valid);
  p_sweep_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FLUSH) && (cnt == IW'(N-1)) |=> lk_ready);
endmodule

// File: tb/xlate_cache_test.sv
module xlate_cache_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic xlat_en = 1'b1, page8k = 1'b0, tc_write = 1'b0;
  logic fl_valid = 1'b0, fl_all = 1'b0, fl_global = 1'b0, fl_super = 1'b0;
  logic [31:0] fl_addr = '0;
  logic lk_valid = 1'b0, lk_super = 1'b0, lk_data = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_addr = '0;
  logic lk_ready, res_valid, res_fault, res_global, res_tt, res_wp;
  logic [31:0] res_phys, fill_addr;
  logic fill_req, fill_super, fill_data, fill_write;
  logic fill_ack = 1'b0;
  logic [19:0] fill_ppn = '0;
  logic [5:0] rsp = '0;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  xlate_cache uut (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .page8k(page8k), .tc_write(tc_write),
    .fl_valid(fl_valid), .fl_all(fl_all), .fl_global(fl_global), .fl_super(fl_super),
    .fl_addr(fl_addr), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .lk_super(lk_super), .lk_data(lk_data), .lk_write(lk_write), .res_valid(res_valid),
    .res_phys(res_phys), .res_fault(res_fault), .res_global(res_global), .res_tt(res_tt),
    .res_wp(res_wp), .fill_req(fill_req), .fill_addr(fill_addr), .fill_super(fill_super),
    .fill_data(fill_data), .fill_write(fill_write), .fill_ack(fill_ack), .fill_ppn(fill_ppn),
    .fill_global(rsp[5]), .fill_tt(rsp[4]), .fill_mod(rsp[3]), .fill_wp(rsp[2]),
    .fill_vd(rsp[1]), .fill_vi(rsp[0]));

  typedef struct packed {
    logic [31:0] a; logic s; logic d; logic w; logic ef;
    logic [19:0] ppn; logic [5:0] fl; logic [31:0] ep; logic efault; logic [3:0] req;
  } vec_t;

  function automatic vec_t mk(logic [31:0] a, logic s, logic d, logic w, logic ef,
                              logic [19:0] ppn, logic [5:0] fl, logic [31:0] ep,
                              logic efault, logic [3:0] req);
    mk = '{a, s, d, w, ef, ppn, fl, ep, efault, req};
  endfunction

  // response flags {global, tt, modified, wp, data-valid, instr-valid}
  localparam vec_t VT [10] = '{
    mk(32'h0001_2345, 0, 1, 0, 1, 20'hABCDE, 6'b001011, 32'hABCD_E345, 0, 3),  // R3 cold miss
    mk(32'h0001_2FFF, 0, 1, 0, 0, 20'h0,     6'b0,      32'hABCD_EFFF, 0, 2),  // R2 hit
    mk(32'h0001_2345, 1, 1, 0, 1, 20'h11111, 6'b101111, 32'h1111_1345, 0, 4),  // R4 other bank
    mk(32'h0001_2010, 1, 1, 1, 0, 20'h0,     6'b0,      32'h1111_1010, 1, 6),  // R6 wp write
    mk(32'h0001_2000, 0, 0, 0, 0, 20'h0,     6'b0,      32'hABCD_E000, 0, 2),  // R2 fetch hit
    mk(32'h0005_2100, 0, 1, 0, 1, 20'h22222, 6'b000010, 32'h2222_2100, 0, 12), // R12 evict
    mk(32'h0005_2104, 0, 0, 0, 0, 20'h0,     6'b0,      32'h2222_2104, 1, 6),  // R6 no instr valid
    mk(32'h0005_2108, 0, 1, 1, 1, 20'h22222, 6'b001010, 32'h2222_2108, 0, 5),  // R5 refill
    mk(32'h0005_2200, 0, 1, 1, 0, 20'h0,     6'b0,      32'h2222_2200, 0, 5),  // R5 now hits
    mk(32'h0001_2345, 0, 1, 0, 1, 20'h33333, 6'b001011, 32'h3333_3345, 0, 12)  // R12 evicted
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic lookup(logic [31:0] a, logic s, logic d, logic w, logic ef,
                        logic [19:0] ppn, logic [5:0] fl, logic [31:0] ep,
                        logic efault, string req);
    logic filled = 1'b0;
    @(negedge clk);
    while (!lk_ready) @(negedge clk);
    lk_addr = a; lk_super = s; lk_data = d; lk_write = w; lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    if (!res_valid && fill_req) begin
      filled = 1'b1;
      chk(req, "fill address", fill_addr, a);
      chk(req, "fill mode bits", {29'd0, fill_super, fill_data, fill_write}, {29'd0, s, d, w});
      fill_ppn = ppn; rsp = fl; fill_ack = 1'b1;
      @(negedge clk);
      fill_ack = 1'b0;
    end
    chk(req, "fill made", {31'd0, filled}, {31'd0, ef});
    chk(req, "result strobe", {31'd0, res_valid}, 32'd1);
    chk(req, "physical address", res_phys, ep);
    chk(req, "fault", {31'd0, res_fault}, {31'd0, efault});
  endtask

  task automatic flush(logic [31:0] a, logic s, logic all, logic glob, logic tc, string req);
    int low = 0;
    @(negedge clk);
    while (!lk_ready) @(negedge clk);
    fl_addr = a; fl_super = s; fl_all = all; fl_global = glob;
    fl_valid = !tc; tc_write = tc;
    @(negedge clk);
    fl_valid = 1'b0; tc_write = 1'b0;
    while (!lk_ready && low < 100) begin low++; @(negedge clk); end
    chk(req, "busy cycles", low, (all || tc) ? 32'd16 : 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", {31'd0, lk_ready}, 32'd1);
    chk("R1", "no result after reset", {31'd0, res_valid}, 32'd0);
    chk("R1", "no fill after reset", {31'd0, fill_req}, 32'd0);

    for (int k = 0; k < 10; k++)
      lookup(VT[k].a, VT[k].s, VT[k].d, VT[k].w, VT[k].ef, VT[k].ppn, VT[k].fl,
             VT[k].ep, VT[k].efault, $sformatf("R%0d", VT[k].req));

    // R8: user bank non-global cleared; supervisor global kept unless qualifier set
    flush(32'h0001_2000, 0, 0, 0, 0, "R8");
    lookup(32'h0001_2345, 0, 1, 0, 1, 20'h33333, 6'b001011, 32'h3333_3345, 0, "R8");
    flush(32'h0001_2000, 1, 0, 0, 0, "R8");
    lookup(32'h0001_2345, 1, 1, 0, 0, 20'h0, 6'b0, 32'h1111_1345, 0, "R8");
    flush(32'h0001_2000, 1, 0, 1, 0, "R8");
    lookup(32'h0001_2345, 1, 1, 0, 1, 20'h11111, 6'b101111, 32'h1111_1345, 0, "R8");
    chk("R2", "global flag", {31'd0, res_global}, 32'd1);

    // R9: paired index in 8K mode, no pairing in 4K mode
    page8k = 1'b1;
    lookup(32'h0000_4000, 0, 1, 0, 1, 20'h44444, 6'b001011, 32'h4444_4000, 0, "R9");
    lookup(32'h0000_5000, 0, 1, 0, 1, 20'h55555, 6'b001011, 32'h5555_5000, 0, "R9");
    flush(32'h0000_4000, 0, 0, 0, 0, "R9");
    lookup(32'h0000_5000, 0, 1, 0, 1, 20'h55555, 6'b001011, 32'h5555_5000, 0, "R9");
    page8k = 1'b0;
    lookup(32'h0000_4000, 0, 1, 0, 1, 20'h44444, 6'b001011, 32'h4444_4000, 0, "R9");
    flush(32'h0000_4000, 0, 0, 0, 0, "R9");
    lookup(32'h0000_5000, 0, 1, 0, 0, 20'h0, 6'b0, 32'h5555_5000, 0, "R9");

    // R10: sweep keeps global supervisor entry, drops user entry
    flush(32'h0, 0, 1, 0, 0, "R10");
    lookup(32'h0001_2345, 1, 1, 0, 0, 20'h0, 6'b0, 32'h1111_1345, 0, "R10");
    lookup(32'h0000_5000, 0, 1, 0, 1, 20'h55555, 6'b001011, 32'h5555_5000, 0, "R10");

    // R11: control write clears global entries as well
    flush(32'h0, 0, 0, 0, 1, "R11");
    lookup(32'h0001_2345, 1, 1, 0, 1, 20'h11111, 6'b101111, 32'h1111_1345, 0, "R11");

    // R7: identity fill without translator
    xlat_en = 1'b0;
    lookup(32'h00AB_C123, 0, 1, 0, 0, 20'h0, 6'b0, 32'h00AB_C123, 0, "R7");
    chk("R7", "identity global", {31'd0, res_global}, 32'd1);
    chk("R7", "identity not wp", {31'd0, res_wp}, 32'd0);
    lookup(32'h00AB_C456, 0, 0, 1, 0, 20'h0, 6'b0, 32'h00AB_C456, 0, "R7");
    xlat_en = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule